// File: doc/BRIEF.md
# Interrupt Aggregator and Output Port Register Bank

This block is a byte-wide control register bank that sits in a 256-byte window of an 8-bit host bus. It samples eight level-type interrupt request lines from neighbouring peripherals into a status register. It gates that register with a host-programmed enable mask and drives a single interrupt request toward the host. By convention, line 0 carries the flash controller, line 1 the card slot, line 2 the USB host, line 3 the serial port and line 4 the display. Lines 5 to 7 are spare.

The same bank holds a 24-bit output data register and a 24-bit output enable register. The block drives out their bitwise AND as the effective output value. In the cycle that follows any write to either register, it marks every bit whose effective value changed. The host reaches every register wider than a byte one byte lane at a time, little-endian.

Reads are combinational from the current address. Writes take effect on the rising clock edge at which `bus_we_i` is high.

Top module: `sysreg_irq_gpo`

## Requirements
- R1: After reset every register reads 0x00, `host_irq_o` is low, and `gpo_val_o` and `gpo_chg_o` are zero.
- R2: Offset 0x08 always reads 0x03 and offset 0x09 always reads 0x00. Writes to either offset have no effect.
- R3: When a source line rises, its bit in the status register (offset 0x50, bit n for line n) is set at the next clock edge. When the line falls, the bit is cleared at the next clock edge.
- R4: A host write to offset 0x50 replaces the status byte. A source line that changes level in the same cycle overrides the written value for its own bit. A written value otherwise holds until that source changes level.
- R5: `host_irq_o` is high exactly when the status byte ANDed with the mask byte (offset 0x52, 1 = enabled) is nonzero. It follows register changes without any further cycle of delay.
- R6: The following registers are little-endian, one byte per address: a 16-bit configuration register at 0x60–0x61, a 32-bit configuration register at 0x9C–0x9F, output data at 0x78–0x7A and output enable at 0x7C–0x7E. A byte write changes only its own lane, and every lane reads back.
- R7: `gpo_val_o` equals the output data register ANDed with the output enable register. It updates at the clock edge that takes a write to either register and is otherwise stable.
- R8: In the cycle after a write to the output data or output enable register, `gpo_chg_o` holds exactly the bits whose effective value changed. That is zero for a write that changes nothing. In every other cycle `gpo_chg_o` is zero.
- R9: A read from any offset not listed in R2–R6 returns 0x00. A write to such an offset (for example 0x53, 0x7B, 0x7F) changes no register and raises no change bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Byte offset within the window |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| irq_src_i | input | 8 | Level interrupt lines from peripherals |
| host_irq_o | output | 1 | Combined, masked interrupt to the host |
| gpo_val_o | output | 24 | Effective output value (data AND enable) |
| gpo_chg_o | output | 24 | One-cycle change bits after an output register write |

## Verification
A status bit with the wrong value shows on `host_irq_o` as soon as its mask bit is set. It also appears in a read of 0x50 one edge after the source moves. A corrupted lane in the output data or enable register shows on `gpo_val_o` one cycle after the write that touched either register. A wrong stored previous value shows on `gpo_chg_o` in that same cycle. If the previous value is wrong, a write that should be silent raises change bits, or a real change goes unmarked. The bench keeps an independent model of every register and of the previous effective value. For each output write, a cycle-stamped expectation is queued and compared in exactly one cycle, and the bench requires `gpo_chg_o` to be zero in every other cycle.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned AW    = 8;
  localparam int unsigned NSRC  = DW;
  localparam int unsigned GPO_W = 24;

  localparam logic [AW-1:0] OFS_REV_LO   = 8'h08;
  localparam logic [AW-1:0] OFS_REV_HI   = 8'h09;
  localparam logic [AW-1:0] OFS_STAT     = 8'h50;
  localparam logic [AW-1:0] OFS_MASK     = 8'h52;
  localparam logic [AW-1:0] OFS_CFG16    = 8'h60;
  localparam logic [AW-1:0] OFS_GPO_DATA = 8'h78;
  localparam logic [AW-1:0] OFS_GPO_OE   = 8'h7C;
  localparam logic [AW-1:0] OFS_CFG32    = 8'h9C;

  localparam logic [DW-1:0] REV_LO = 8'h03;
  localparam logic [DW-1:0] REV_HI = 8'h00;
endpackage

// File: rtl/sysreg_lane_reg.sv
module sysreg_lane_reg #(
  parameter int unsigned LANES = 1,
  parameter logic [7:0]  BASE  = 8'h00
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [7:0]           addr_i,
  input  logic [7:0]           wdata_i,
  output logic [LANES*8-1:0]   q_o,
  output logic [LANES*8-1:0]   nxt_o,
  output logic                 hit_o,
  output logic [7:0]           rdata_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] lane_q;
    logic       sel;
    assign sel = (addr_i == BASE + 8'(i));
    assign nxt_o[i*8 +: 8] = (we_i && sel) ? wdata_i : lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_q <= '0;
      else         lane_q <= nxt_o[i*8 +: 8];
    end
    assign q_o[i*8 +: 8] = lane_q;
  end

  always_comb begin
    hit_o   = 1'b0;
    rdata_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (addr_i == BASE + 8'(i)) begin
        hit_o   = 1'b1;
        rdata_o = q_o[i*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/sysreg_irq_combine.sv
module sysreg_irq_combine #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            stat_we_i,
  input  logic [NSRC-1:0] stat_wdata_i,
  input  logic [NSRC-1:0] mask_i,
  output logic [NSRC-1:0] stat_o,
  output logic [NSRC-1:0] seen_o,
  output logic            irq_o
);
  logic [NSRC-1:0] stat_q, seen_q, base, rise, fall, stat_d;

  always_comb begin
    base   = stat_we_i ? stat_wdata_i : stat_q;
    rise   = src_i & ~seen_q;
    fall   = ~src_i & seen_q;
    // a level change on a line beats a host write to its bit
    stat_d = (base | rise) & ~fall;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      seen_q <= '0;
    end else begin
      stat_q <= stat_d;
      seen_q <= src_i;
    end
  end

  assign stat_o = stat_q;
  assign seen_o = seen_q;
  assign irq_o  = |(stat_q & mask_i);
endmodule

// File: rtl/sysreg_gpo_track.sv
module sysreg_gpo_track #(
  parameter int unsigned GPO_W     = 24,
  parameter logic [7:0]  DATA_BASE = 8'h78,
  parameter logic [7:0]  OE_BASE   = 8'h7C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [GPO_W-1:0] val_o,
  output logic [GPO_W-1:0] chg_o,
  output logic             hit_o,
  output logic             wr_o,
  output logic [7:0]       rdata_o
);
  localparam int unsigned LANES = GPO_W / 8;

  logic [GPO_W-1:0] data_q, data_nxt, oe_q, oe_nxt, eff_nxt, val_q, chg_q;
  logic             hit_data, hit_oe;
  logic [7:0]       rd_data, rd_oe;

  sysreg_lane_reg #(.LANES(LANES), .BASE(DATA_BASE)) u_data (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .q_o(data_q), .nxt_o(data_nxt), .hit_o(hit_data), .rdata_o(rd_data)
  );

  sysreg_lane_reg #(.LANES(LANES), .BASE(OE_BASE)) u_oe (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .q_o(oe_q), .nxt_o(oe_nxt), .hit_o(hit_oe), .rdata_o(rd_oe)
  );

  assign hit_o   = hit_data | hit_oe;
  assign wr_o    = we_i & hit_o;
  assign eff_nxt = data_nxt & oe_nxt;
  assign rdata_o = hit_data ? rd_data : rd_oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      chg_q <= '0;
    end else if (wr_o) begin
      val_q <= eff_nxt;
      chg_q <= eff_nxt ^ val_q;
    end else begin
      chg_q <= '0;
    end
  end

  assign val_o = val_q;
  assign chg_o = chg_q;
endmodule

// File: rtl/sysreg_irq_gpo.sv
module sysreg_irq_gpo
  import sysreg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  input  logic             bus_we_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic [NSRC-1:0]  irq_src_i,
  output logic             host_irq_o,
  output logic [GPO_W-1:0] gpo_val_o,
  output logic [GPO_W-1:0] gpo_chg_o
);
  logic [NSRC-1:0] stat_q, mask_q, src_seen, mask_nxt;
  logic            stat_we, mask_hit, c16_hit, c32_hit, gpo_hit, gpo_wr;
  logic [7:0]      mask_rd, c16_rd, c32_rd, gpo_rd;
  logic [15:0]     c16_q, c16_nxt;
  logic [31:0]     c32_q, c32_nxt;

  assign stat_we = bus_we_i && (bus_addr_i == OFS_STAT);

  sysreg_lane_reg #(.LANES(1), .BASE(OFS_MASK)) u_mask (
    .clk_i, .rst_ni, .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .q_o(mask_q), .nxt_o(mask_nxt), .hit_o(mask_hit), .rdata_o(mask_rd)
  );

  sysreg_lane_reg #(.LANES(2), .BASE(OFS_CFG16)) u_cfg16 (
    .clk_i, .rst_ni, .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .q_o(c16_q), .nxt_o(c16_nxt), .hit_o(c16_hit), .rdata_o(c16_rd)
  );

  sysreg_lane_reg #(.LANES(4), .BASE(OFS_CFG32)) u_cfg32 (
    .clk_i, .rst_ni, .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .q_o(c32_q), .nxt_o(c32_nxt), .hit_o(c32_hit), .rdata_o(c32_rd)
  );

  sysreg_irq_combine #(.NSRC(NSRC)) u_irq (
    .clk_i, .rst_ni, .src_i(irq_src_i), .stat_we_i(stat_we),
    .stat_wdata_i(bus_wdata_i), .mask_i(mask_q),
    .stat_o(stat_q), .seen_o(src_seen), .irq_o(host_irq_o)
  );

  sysreg_gpo_track #(.GPO_W(GPO_W), .DATA_BASE(OFS_GPO_DATA), .OE_BASE(OFS_GPO_OE)) u_gpo (
    .clk_i, .rst_ni, .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .val_o(gpo_val_o), .chg_o(gpo_chg_o), .hit_o(gpo_hit), .wr_o(gpo_wr),
    .rdata_o(gpo_rd)
  );

  always_comb begin
    bus_rdata_o = '0;
    if      (bus_addr_i == OFS_REV_LO) bus_rdata_o = REV_LO;
    else if (bus_addr_i == OFS_REV_HI) bus_rdata_o = REV_HI;
    else if (bus_addr_i == OFS_STAT)   bus_rdata_o = stat_q;
    else if (mask_hit)                 bus_rdata_o = mask_rd;
    else if (c16_hit)                  bus_rdata_o = c16_rd;
    else if (c32_hit)                  bus_rdata_o = c32_rd;
    else if (gpo_hit)                  bus_rdata_o = gpo_rd;
  end
endmodule

// File: rtl/sysreg_irq_gpo_chk.sv
module sysreg_irq_gpo_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  bus_addr_i,
  input logic [7:0]  bus_rdata_o,
  input logic [7:0]  irq_src_i,
  input logic [7:0]  src_seen,
  input logic [7:0]  stat_q,
  input logic [7:0]  mask_q,
  input logic        host_irq_o,
  input logic        gpo_wr,
  input logic [23:0] gpo_val_o,
  input logic [23:0] gpo_chg_o
);
  AST_REV_LO_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == 8'h08 |-> bus_rdata_o == 8'h03); // R2
  AST_REV_HI_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == 8'h09 |-> bus_rdata_o == 8'h00); // R2
  AST_RISE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(irq_src_i & ~src_seen)) |=>
      ((stat_q & $past(irq_src_i & ~src_seen)) == $past(irq_src_i & ~src_seen))); // R3
  AST_FALL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~irq_src_i & src_seen)) |=> ((stat_q & $past(~irq_src_i & src_seen)) == 8'h00)); // R3
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q == 8'h00 |-> !host_irq_o); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q == 8'h00 |-> !host_irq_o); // R5
  AST_VAL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gpo_wr |=> $stable(gpo_val_o)); // R7
  AST_CHG_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gpo_wr |=> gpo_chg_o == 24'h0); // R8
  AST_CHG_IS_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpo_wr |=> gpo_chg_o == ($past(gpo_val_o) ^ gpo_val_o)); // R8
endmodule

bind sysreg_irq_gpo sysreg_irq_gpo_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o),
  .irq_src_i(irq_src_i), .src_seen(src_seen), .stat_q(stat_q), .mask_q(mask_q),
  .host_irq_o(host_irq_o), .gpo_wr(gpo_wr), .gpo_val_o(gpo_val_o), .gpo_chg_o(gpo_chg_o)
);

// File: tb/sim_sysreg_irq_gpo.sv
module sim_sysreg_irq_gpo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0, wdata = '0, rdata;
  logic        we = 1'b0;
  logic [7:0]  src = '0;
  logic        irq;
  logic [23:0] val, chg;

  int unsigned cyc = 0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  typedef struct {
    int unsigned cyc;
    logic [23:0] val;
    logic [23:0] chg;
  } exp_t;
  exp_t exp_q[$];

  logic [23:0] m_data = '0, m_oe = '0, m_val = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sysreg_irq_gpo u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_we_i(we), .bus_rdata_o(rdata), .irq_src_i(src), .host_irq_o(irq),
    .gpo_val_o(val), .gpo_chg_o(chg)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    if (a >= 8'h78 && a <= 8'h7A) m_data[(a-8'h78)*8 +: 8] = d;
    if (a >= 8'h7C && a <= 8'h7E) m_oe[(a-8'h7C)*8 +: 8] = d;
    if ((a >= 8'h78 && a <= 8'h7A) || (a >= 8'h7C && a <= 8'h7E)) begin
      logic [23:0] nv;
      nv = m_data & m_oe;
      exp_q.push_back('{cyc + 1, nv, nv ^ m_val});
      m_val = nv;
    end
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1;
    check(tag, {24'h0, rdata}, {24'h0, exp});
  endtask

  // scoreboard monitor for the output port path
  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        check("R7 gpo_val", {8'h0, val}, {8'h0, e.val});
        check("R8 gpo_chg", {8'h0, chg}, {8'h0, e.chg});
      end else if (chg !== 24'h0) begin
        check("R8 chg idle", {8'h0, chg}, 32'h0);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h50, 8'h00, "R1 stat");
    rd(8'h52, 8'h00, "R1 mask");
    rd(8'h7C, 8'h00, "R1 oe");
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 val", {8'h0, val}, 32'h0);
    // R2 revision
    rd(8'h08, 8'h03, "R2 rev lo");
    rd(8'h09, 8'h00, "R2 rev hi");
    wr(8'h08, 8'h5A);
    rd(8'h08, 8'h03, "R2 rev lo after write");
    // R3 / R5 source level tracking and masking
    @(negedge clk); src = 8'h04;
    rd(8'h50, 8'h04, "R3 rise sets");
    check("R5 masked off", {31'h0, irq}, 32'h0);
    wr(8'h52, 8'h04);
    check("R5 enabled", {31'h0, irq}, 32'h1);
    @(negedge clk); src = 8'h00;
    rd(8'h50, 8'h00, "R3 fall clears");
    check("R5 cleared", {31'h0, irq}, 32'h0);
    // R4 host write
    wr(8'h52, 8'h80);
    wr(8'h50, 8'h81);
    rd(8'h50, 8'h81, "R4 host write");
    check("R5 host bit", {31'h0, irq}, 32'h1);
    wr(8'h50, 8'h00);
    check("R5 after clear", {31'h0, irq}, 32'h0);
    @(negedge clk); src = 8'h02; addr = 8'h50; wdata = 8'h00; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(8'h50, 8'h02, "R4 rise beats write");
    wr(8'h50, 8'h00);
    rd(8'h50, 8'h00, "R4 write holds while level steady");
    wr(8'h50, 8'h02);
    @(negedge clk); src = 8'h00; addr = 8'h50; wdata = 8'h02; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(8'h50, 8'h00, "R4 fall beats write");
    // R6 byte lanes
    wr(8'h9C, 8'h11); wr(8'h9D, 8'h22); wr(8'h9E, 8'h33); wr(8'h9F, 8'h44);
    wr(8'h9E, 8'hAA);
    rd(8'h9C, 8'h11, "R6 cfg32 b0");
    rd(8'h9D, 8'h22, "R6 cfg32 b1");
    rd(8'h9E, 8'hAA, "R6 cfg32 b2");
    rd(8'h9F, 8'h44, "R6 cfg32 b3");
    wr(8'h61, 8'h5A);
    rd(8'h60, 8'h00, "R6 cfg16 b0");
    rd(8'h61, 8'h5A, "R6 cfg16 b1");
    // R7 / R8 output port
    wr(8'h78, 8'hFF);
    wr(8'h7C, 8'h0F);
    wr(8'h7E, 8'h80);
    wr(8'h7A, 8'h80);
    wr(8'h78, 8'hF0);
    rd(8'h78, 8'hF0, "R6 gpo data b0");
    rd(8'h79, 8'h00, "R6 gpo data b1");
    rd(8'h7A, 8'h80, "R6 gpo data b2");
    rd(8'h7C, 8'h0F, "R6 gpo oe b0");
    rd(8'h7E, 8'h80, "R6 gpo oe b2");
    check("R7 val now", {8'h0, val}, 32'h00800000);
    // R9 unmapped
    rd(8'h40, 8'h00, "R9 read unmapped");
    wr(8'h53, 8'hFF);
    rd(8'h52, 8'h80, "R9 mask untouched");
    rd(8'h53, 8'h00, "R9 read 0x53");
    wr(8'h7B, 8'hFF);
    wr(8'h7F, 8'hFF);
    rd(8'h7B, 8'h00, "R9 read 0x7B");
    check("R9 val untouched", {8'h0, val}, 32'h00800000);
    wr(8'h09, 8'h55);
    rd(8'h09, 8'h00, "R9 rev hi write");
    repeat (4) @(negedge clk);
    check("R8 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule